// File: doc/BRIEF.md
# Seven-Channel Thermal Alarm Supervisor

The block watches seven on-die temperature sensor channels. A programmable timer starts a sweep over the channels. During a sweep, each selected channel gets one strobe cycle, and in that cycle the block captures a 9-bit conversion code from a sample port. Codes grow with temperature. Each channel has its own alarm threshold and its own shutdown threshold, and each path has a consecutive-sample debounce. A debounced alarm sets a sticky interrupt bit. A debounced shutdown sets a sticky shutdown bit. That bit then drives a board-level shutdown pin, a reset-unit request, or both.

Software programs the block through a simple 32-bit memory-mapped register bus. Reads are combinational. A write takes effect at the clock edge on which `bus_req_i` and `bus_we_i` are both high. The control register and the four per-channel enable registers use a half-word write mask: bit n+16 of the write data must be set for bit n to change. While any channel's most recent sample is at or above its alarm threshold, the timer switches to a second, usually shorter, "hot" period.

Top module: `thermal_guard`

## Requirements
- R1: After reset, the register values are as follows: control reads 0; both scan periods read 5000; both debounce counts read 4; every threshold reads 0x1ff; all enable and pending registers read 0. After reset, `irq_o` is 0, `shut_rst_o` is 0 and `shut_pin_o` is 1 (the pin is inactive at the default active-low polarity).
- R2: The control register (0x000) and the enable registers (0x00c, 0x014, 0x018, 0x01c) change bit n only when write bit n+16 is 1. All other bits keep their value. Control bit 0 is the scan enable. Control bit 8 is the shutdown pin polarity (1 = active-high, 0 = active-low).
- R3: With scanning on, a sweep starts once every period cycles. The sweep visits channels 0 to 6 in order, one per cycle. `smp_stb_o` is raised only for channels whose bit is set in the shutdown-source enable (0x00c) or the alarm enable (0x014). The data register at 0x02c+4n returns that channel's last captured code, zero-extended. A channel that is never strobed reads 0.
- R4: With scanning off, no strobe is raised and every debounce counter is cleared, so over-threshold runs do not carry across a disable.
- R5: The alarm pending bit n is set when a run of consecutive channel-n samples with code ≥ threshold (0x06c+4n) reaches the alarm debounce count (0x148). A sample below the threshold restarts the run. A count of 0 acts as 1.
- R6: `irq_o` is the OR of the interrupt pending bits (0x024) whose alarm enable bit is set.
- R7: The pending registers 0x024 and 0x028 are sticky. Writing 1 to a bit clears it. If a new event and a clear fall on the same edge, the event wins.
- R8: Shutdown pending bit n (0x028) is set only if the shutdown-source enable bit n is set. The shutdown run uses threshold 0x10c+4n and debounce count 0x14c.
- R9: The reset-unit output `shut_rst_o` is active-high. It is asserted while any shutdown pending bit has its reset-unit route bit (0x01c) set. The pin is active while any shutdown pending bit has its pin route bit (0x018) set.
- R10: `shut_pin_o` equals the pin-active state when polarity is high, and its inverse when polarity is low.
- R11: While any channel's last sample was at or above its alarm threshold, the sweep interval is the hot period (0x144). Otherwise it is the normal period (0x140).
- R12: Reads of any address outside the map (0x000, 0x00c, 0x014, 0x018, 0x01c, 0x024, 0x028, 0x02c+4n, 0x06c+4n, 0x10c+4n, 0x140, 0x144, 0x148, 0x14c) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational from address) |
| smp_stb_o | output | 1 | Sample capture strobe for `smp_ch_o` |
| smp_ch_o | output | 3 | Channel being swept |
| smp_code_i | input | 9 | Conversion code of channel `smp_ch_o` |
| irq_o | output | 1 | High-temperature interrupt |
| shut_pin_o | output | 1 | Shutdown pin, polarity per control bit 8 |
| shut_rst_o | output | 1 | Shutdown request to reset unit, active high |

## Verification
The assertions assume two things. First, `smp_code_i` is valid in any cycle where `smp_stb_o` is high. Second, the bus address is stable for the whole write cycle. The bench meets both: it models the sensors as an array indexed combinationally by `smp_ch_o`, and it drives bus signals only on falling edges. The assertions also assume that pending bits fall only because of a bus clear. To keep that true, the stimulus never resets mid-run. It changes a sensor code only after the strobe for that channel has been captured, and it counts strobes per channel, so every debounce expectation is tied to an exact sample number.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int ADDR_W       = 12;
  localparam int DATA_W       = 32;
  localparam int A_CTRL       = 'h000;
  localparam int A_SRC_EN     = 'h00c;
  localparam int A_ALM_EN     = 'h014;
  localparam int A_PIN_EN     = 'h018;
  localparam int A_RST_EN     = 'h01c;
  localparam int A_INT_PND    = 'h024;
  localparam int A_SHT_PND    = 'h028;
  localparam int A_DATA0      = 'h02c;
  localparam int A_ALM_THR0   = 'h06c;
  localparam int A_SHT_THR0   = 'h10c;
  localparam int A_PERIOD     = 'h140;
  localparam int A_PERIOD_HOT = 'h144;
  localparam int A_DBN_ALM    = 'h148;
  localparam int A_DBN_SHT    = 'h14c;
  localparam int PERIOD_RST   = 5000;
  localparam int DBN_RST      = 4;
endpackage

// File: rtl/thm_dbnc.sv
module thm_dbnc #(
  parameter int DBN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             over_i,
  input  logic [DBN_W-1:0] lim_i,
  output logic             fire_o
);
  logic [DBN_W-1:0] cnt_q, lim_eff;

  assign lim_eff = (lim_i == '0) ? DBN_W'(1) : lim_i;
  assign fire_o  = stb_i & over_i & (cnt_q >= lim_eff - DBN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (stb_i) begin
      if (!over_i)                    cnt_q <= '0;
      else if (cnt_q < lim_eff)       cnt_q <= cnt_q + DBN_W'(1);
    end
  end
endmodule

// File: rtl/thm_chan.sv
module thm_chan #(
  parameter int CODE_W = 9,
  parameter int DBN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic              stb_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] alm_thr_i,
  input  logic [CODE_W-1:0] sht_thr_i,
  input  logic [DBN_W-1:0]  dbn_alm_i,
  input  logic [DBN_W-1:0]  dbn_sht_i,
  input  logic              sht_src_i,
  output logic [CODE_W-1:0] data_o,
  output logic              hot_o,
  output logic              int_set_o,
  output logic              sht_set_o
);
  logic over_alm, over_sht, fire_sht;

  assign over_alm = code_i >= alm_thr_i;
  assign over_sht = code_i >= sht_thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      hot_o  <= 1'b0;
    end else if (!scan_en_i) begin
      hot_o  <= 1'b0;
    end else if (stb_i) begin
      data_o <= code_i;
      hot_o  <= over_alm;
    end
  end

  thm_dbnc #(.DBN_W(DBN_W)) u_alm (
    .clk_i, .rst_ni, .clr_i(!scan_en_i), .stb_i, .over_i(over_alm),
    .lim_i(dbn_alm_i), .fire_o(int_set_o)
  );

  thm_dbnc #(.DBN_W(DBN_W)) u_sht (
    .clk_i, .rst_ni, .clr_i(!scan_en_i), .stb_i, .over_i(over_sht),
    .lim_i(dbn_sht_i), .fire_o(fire_sht)
  );

  assign sht_set_o = fire_sht & sht_src_i;
endmodule

// File: rtl/thm_scan.sv
module thm_scan #(
  parameter int NUM_CH = 7,
  parameter int TMR_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic              hot_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [TMR_W-1:0]  period_hot_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  output logic              stb_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [TMR_W-1:0] tmr_q, lim;
  logic             sweep_q, roll;

  assign lim   = hot_i ? period_hot_i : period_period_sel();
  function automatic logic [TMR_W-1:0] period_period_sel();
    return period_i;
  endfunction
  assign roll  = ({1'b0, tmr_q} + (TMR_W+1)'(1)) >= {1'b0, lim};
  assign stb_o = sweep_q & chan_en_i[ch_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      sweep_q <= 1'b0;
      ch_o    <= '0;
    end else if (!scan_en_i) begin
      tmr_q   <= '0;
      sweep_q <= 1'b0;
      ch_o    <= '0;
    end else begin
      tmr_q <= roll ? '0 : tmr_q + TMR_W'(1);
      if (sweep_q) begin
        if (ch_o == CH_W'(NUM_CH-1)) begin
          sweep_q <= 1'b0;
          ch_o    <= '0;
        end else begin
          ch_o    <= ch_o + CH_W'(1);
        end
      end else if (roll) begin
        sweep_q <= 1'b1;
        ch_o    <= '0;
      end
    end
  end
endmodule

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CODE_W = 9,
  parameter int TMR_W  = 16,
  parameter int DBN_W  = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_req_i,
  input  logic                           bus_we_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  smp_data_i,
  input  logic [NUM_CH-1:0]              int_set_i,
  input  logic [NUM_CH-1:0]              sht_set_i,
  output logic                           scan_en_o,
  output logic                           pol_hi_o,
  output logic [NUM_CH-1:0]              src_en_o,
  output logic [NUM_CH-1:0]              alm_en_o,
  output logic [NUM_CH-1:0]              pin_en_o,
  output logic [NUM_CH-1:0]              rst_en_o,
  output logic [NUM_CH-1:0]              int_pnd_o,
  output logic [NUM_CH-1:0]              sht_pnd_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  alm_thr_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  sht_thr_o,
  output logic [TMR_W-1:0]               period_o,
  output logic [TMR_W-1:0]               period_hot_o,
  output logic [DBN_W-1:0]               dbn_alm_o,
  output logic [DBN_W-1:0]               dbn_sht_o
);
  logic wr;
  logic [NUM_CH-1:0] wd, wm, int_clr, sht_clr;

  assign wr = bus_req_i & bus_we_i;
  assign wd = bus_wdata_i[NUM_CH-1:0];
  assign wm = bus_wdata_i[16 +: NUM_CH];
  assign int_clr = (wr && bus_addr_i == ADDR_W'(A_INT_PND)) ? wd : '0;
  assign sht_clr = (wr && bus_addr_i == ADDR_W'(A_SHT_PND)) ? wd : '0;

  function automatic logic [NUM_CH-1:0] mwr(input logic [NUM_CH-1:0] old_v);
    return (old_v & ~wm) | (wd & wm);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_en_o    <= 1'b0;
      pol_hi_o     <= 1'b0;
      src_en_o     <= '0;
      alm_en_o     <= '0;
      pin_en_o     <= '0;
      rst_en_o     <= '0;
      int_pnd_o    <= '0;
      sht_pnd_o    <= '0;
      alm_thr_o    <= '1;
      sht_thr_o    <= '1;
      period_o     <= TMR_W'(PERIOD_RST);
      period_hot_o <= TMR_W'(PERIOD_RST);
      dbn_alm_o    <= DBN_W'(DBN_RST);
      dbn_sht_o    <= DBN_W'(DBN_RST);
    end else begin
      // set beats clear on the same edge
      int_pnd_o <= (int_pnd_o & ~int_clr) | int_set_i;
      sht_pnd_o <= (sht_pnd_o & ~sht_clr) | sht_set_i;
      if (wr) begin
        case (bus_addr_i)
          ADDR_W'(A_CTRL): begin
            if (bus_wdata_i[16]) scan_en_o <= bus_wdata_i[0];
            if (bus_wdata_i[24]) pol_hi_o  <= bus_wdata_i[8];
          end
          ADDR_W'(A_SRC_EN):     src_en_o     <= mwr(src_en_o);
          ADDR_W'(A_ALM_EN):     alm_en_o     <= mwr(alm_en_o);
          ADDR_W'(A_PIN_EN):     pin_en_o     <= mwr(pin_en_o);
          ADDR_W'(A_RST_EN):     rst_en_o     <= mwr(rst_en_o);
          ADDR_W'(A_PERIOD):     period_o     <= bus_wdata_i[TMR_W-1:0];
          ADDR_W'(A_PERIOD_HOT): period_hot_o <= bus_wdata_i[TMR_W-1:0];
          ADDR_W'(A_DBN_ALM):    dbn_alm_o    <= bus_wdata_i[DBN_W-1:0];
          ADDR_W'(A_DBN_SHT):    dbn_sht_o    <= bus_wdata_i[DBN_W-1:0];
          default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
          if (bus_addr_i == ADDR_W'(A_ALM_THR0 + 4*i)) alm_thr_o[i] <= bus_wdata_i[CODE_W-1:0];
          if (bus_addr_i == ADDR_W'(A_SHT_THR0 + 4*i)) sht_thr_o[i] <= bus_wdata_i[CODE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(A_CTRL):       bus_rdata_o = DATA_W'({pol_hi_o, 7'b0, scan_en_o});
      ADDR_W'(A_SRC_EN):     bus_rdata_o = DATA_W'(src_en_o);
      ADDR_W'(A_ALM_EN):     bus_rdata_o = DATA_W'(alm_en_o);
      ADDR_W'(A_PIN_EN):     bus_rdata_o = DATA_W'(pin_en_o);
      ADDR_W'(A_RST_EN):     bus_rdata_o = DATA_W'(rst_en_o);
      ADDR_W'(A_INT_PND):    bus_rdata_o = DATA_W'(int_pnd_o);
      ADDR_W'(A_SHT_PND):    bus_rdata_o = DATA_W'(sht_pnd_o);
      ADDR_W'(A_PERIOD):     bus_rdata_o = DATA_W'(period_o);
      ADDR_W'(A_PERIOD_HOT): bus_rdata_o = DATA_W'(period_hot_o);
      ADDR_W'(A_DBN_ALM):    bus_rdata_o = DATA_W'(dbn_alm_o);
      ADDR_W'(A_DBN_SHT):    bus_rdata_o = DATA_W'(dbn_sht_o);
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr_i == ADDR_W'(A_DATA0 + 4*i))    bus_rdata_o = DATA_W'(smp_data_i[i]);
      if (bus_addr_i == ADDR_W'(A_ALM_THR0 + 4*i)) bus_rdata_o = DATA_W'(alm_thr_o[i]);
      if (bus_addr_i == ADDR_W'(A_SHT_THR0 + 4*i)) bus_rdata_o = DATA_W'(sht_thr_o[i]);
    end
  end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thm_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CODE_W = 9,
  parameter int TMR_W  = 16,
  parameter int DBN_W  = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              smp_stb_o,
  output logic [CH_W-1:0]   smp_ch_o,
  input  logic [CODE_W-1:0] smp_code_i,
  output logic              irq_o,
  output logic              shut_pin_o,
  output logic              shut_rst_o
);
  logic scan_en, pol_hi, pin_act;
  logic [NUM_CH-1:0] src_en, alm_en, pin_en, rst_en, int_pnd, sht_pnd;
  logic [NUM_CH-1:0] int_set, sht_set, hot;
  logic [NUM_CH-1:0][CODE_W-1:0] alm_thr, sht_thr, smp_data;
  logic [TMR_W-1:0] period, period_hot;
  logic [DBN_W-1:0] dbn_alm, dbn_sht;

  thm_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .TMR_W(TMR_W), .DBN_W(DBN_W)) u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .smp_data_i(smp_data), .int_set_i(int_set), .sht_set_i(sht_set),
    .scan_en_o(scan_en), .pol_hi_o(pol_hi), .src_en_o(src_en), .alm_en_o(alm_en),
    .pin_en_o(pin_en), .rst_en_o(rst_en), .int_pnd_o(int_pnd), .sht_pnd_o(sht_pnd),
    .alm_thr_o(alm_thr), .sht_thr_o(sht_thr), .period_o(period),
    .period_hot_o(period_hot), .dbn_alm_o(dbn_alm), .dbn_sht_o(dbn_sht)
  );

  thm_scan #(.NUM_CH(NUM_CH), .TMR_W(TMR_W)) u_scan (
    .clk_i, .rst_ni, .scan_en_i(scan_en), .hot_i(|hot), .period_i(period),
    .period_hot_i(period_hot), .chan_en_i(src_en | alm_en),
    .stb_o(smp_stb_o), .ch_o(smp_ch_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    thm_chan #(.CODE_W(CODE_W), .DBN_W(DBN_W)) u_chan (
      .clk_i, .rst_ni, .scan_en_i(scan_en),
      .stb_i(smp_stb_o && smp_ch_o == CH_W'(g)), .code_i(smp_code_i),
      .alm_thr_i(alm_thr[g]), .sht_thr_i(sht_thr[g]),
      .dbn_alm_i(dbn_alm), .dbn_sht_i(dbn_sht), .sht_src_i(src_en[g]),
      .data_o(smp_data[g]), .hot_o(hot[g]),
      .int_set_o(int_set[g]), .sht_set_o(sht_set[g])
    );
  end

  assign irq_o      = |(int_pnd & alm_en);
  assign pin_act    = |(sht_pnd & pin_en);
  assign shut_pin_o = pol_hi ? pin_act : ~pin_act;
  assign shut_rst_o = |(sht_pnd & rst_en);
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk
  import thm_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              scan_en,
  input logic              smp_stb_o,
  input logic [CH_W-1:0]   smp_ch_o,
  input logic [NUM_CH-1:0] int_pnd,
  input logic [NUM_CH-1:0] sht_pnd,
  input logic [NUM_CH-1:0] src_en,
  input logic [NUM_CH-1:0] rst_en,
  input logic              irq_o,
  input logic              shut_rst_o
);
  AST_STB_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o |-> (smp_ch_o <= CH_W'(NUM_CH-1))); // R3
  AST_NO_STB_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en |=> !smp_stb_o); // R4
  AST_IRQ_HAS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int_pnd != '0)); // R6
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(int_pnd) & ~int_pnd)) |->
      ($past(bus_req_i) && $past(bus_we_i) && $past(bus_addr_i) == ADDR_W'(A_INT_PND))); // R7
  AST_SHUT_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sht_pnd & ~$past(sht_pnd) & ~$past(src_en)))); // R8
  AST_RST_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_rst_o |-> (|(sht_pnd & rst_en))); // R9
endmodule

bind thermal_guard thermal_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .scan_en(scan_en), .smp_stb_o(smp_stb_o),
  .smp_ch_o(smp_ch_o), .int_pnd(int_pnd), .sht_pnd(sht_pnd), .src_en(src_en),
  .rst_en(rst_en), .irq_o(irq_o), .shut_rst_o(shut_rst_o)
);

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        stb, irq, pin, rstu;
  logic [2:0]  ch;
  logic [8:0]  code;
  logic [8:0]  sens [0:7];

  assign code = sens[ch];

  thermal_guard u_thermal_guard (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .smp_stb_o(stb), .smp_ch_o(ch), .smp_code_i(code),
    .irq_o(irq), .shut_pin_o(pin), .shut_rst_o(rstu)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  event        mon_ev;

  // scoreboard monitor
  always @(mon_ev) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_chk++;
    if (rdata !== e) begin
      n_err++;
      $display("FAIL %s: got %h exp %h", t, rdata, e);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1; exp_q.push_back(e); tag_q.push_back(t); ->mon_ev;
    #1; req = 0;
  endtask

  task automatic chk(input string t, input logic [31:0] g, input logic [31:0] e);
    n_chk++;
    if (g !== e) begin
      n_err++;
      $display("FAIL %s: got %h exp %h", t, g, e);
    end
  endtask

  task automatic wait_smp(input int c, input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (stb && ch == 3'(c)) k++;
    end
    @(posedge clk); #1;
  endtask

  task automatic gap(input int c, output int g);
    do @(negedge clk); while (!(stb && ch == 3'(c)));
    g = 0;
    do begin @(negedge clk); g++; end while (!(stb && ch == 3'(c)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R3: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int g;
    int cnt;
    for (int i = 0; i < 8; i++) sens[i] = 9'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, 32'h0, "R1 ctrl");
    rd(12'h140, 32'd5000, "R1 period");
    rd(12'h144, 32'd5000, "R1 hot period");
    rd(12'h148, 32'd4, "R1 alarm debounce");
    rd(12'h14c, 32'd4, "R1 shutdown debounce");
    rd(12'h074, 32'h1ff, "R1 alarm thr ch2");
    rd(12'h024, 32'h0, "R1 int pending");
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 pin idle high", 32'(pin), 32'd1);
    chk("R1 reset-unit", 32'(rstu), 32'd0);

    // R2 masked writes
    wr(12'h000, 32'h0000_0101); rd(12'h000, 32'h0, "R2 no mask");
    wr(12'h000, 32'h0001_0101); rd(12'h000, 32'h1, "R2 bit0 only");
    wr(12'h000, 32'h0100_0100); rd(12'h000, 32'h101, "R2 bit8 set");
    wr(12'h000, 32'h0001_0000); rd(12'h000, 32'h100, "R2 bit0 clear");
    wr(12'h000, 32'h0100_0000); rd(12'h000, 32'h0, "R2 pol clear");
    wr(12'h014, 32'h0001_007f); rd(12'h014, 32'h1, "R2 alarm en ch0");

    // R12 map
    rd(12'h008, 32'h0, "R12 hole");
    rd(12'h3fc, 32'h0, "R12 high hole");
    wr(12'h078, 32'd300); rd(12'h078, 32'd300, "R12 alarm thr ch3");

    // setup
    wr(12'h140, 32'd20); wr(12'h144, 32'd20);
    wr(12'h148, 32'd3);  wr(12'h14c, 32'd2);
    wr(12'h124, 32'd350);          // shut thr ch6
    wr(12'h10c, 32'd100);          // shut thr ch0
    wr(12'h00c, 32'h0048_0048);    // src en ch3, ch6
    wr(12'h018, 32'h0040_0040);    // pin route ch6
    sens[0] = 9'd99; sens[3] = 9'd120; sens[6] = 9'd130;
    wr(12'h000, 32'h0001_0001);

    // R3 scan and data
    wait_smp(6, 1);
    rd(12'h02c, 32'd99, "R3 data ch0");
    rd(12'h038, 32'd120, "R3 data ch3");
    rd(12'h044, 32'd130, "R3 data ch6");
    rd(12'h030, 32'd0, "R3 unscanned ch1");

    // R5 debounce, R6 irq
    sens[3] = 9'd300;
    wait_smp(3, 2); rd(12'h024, 32'h0, "R5 two samples");
    wait_smp(3, 1); rd(12'h024, 32'h8, "R5 third sample");
    chk("R6 irq gated", 32'(irq), 32'd0);
    wr(12'h014, 32'h0008_0008);
    chk("R6 irq enabled", 32'(irq), 32'd1);

    // R7 clear while still hot
    wr(12'h024, 32'h8); rd(12'h024, 32'h0, "R7 cleared");
    wait_smp(3, 1); rd(12'h024, 32'h8, "R7 re-set");
    sens[3] = 9'd100; wait_smp(3, 1);
    wr(12'h024, 32'h8); rd(12'h024, 32'h0, "R7 clear cold");
    chk("R6 irq off", 32'(irq), 32'd0);

    // R5 broken run
    sens[3] = 9'd300; wait_smp(3, 2);
    sens[3] = 9'd100; wait_smp(3, 1);
    sens[3] = 9'd300; wait_smp(3, 2);
    rd(12'h024, 32'h0, "R5 run restarted");
    wait_smp(3, 1); rd(12'h024, 32'h8, "R5 run complete");
    sens[3] = 9'd100; wait_smp(3, 1); wr(12'h024, 32'h8);

    // R8 source gate, R9 routes, R10 polarity
    sens[0] = 9'd200; sens[6] = 9'd360;
    wait_smp(6, 1); rd(12'h028, 32'h0, "R8 one sample");
    wait_smp(6, 1); rd(12'h028, 32'h40, "R8 ch6 only, ch0 gated");
    chk("R9 pin active low", 32'(pin), 32'd0);
    chk("R9 reset-unit unrouted", 32'(rstu), 32'd0);
    wr(12'h01c, 32'h0040_0040);
    chk("R9 reset-unit routed", 32'(rstu), 32'd1);
    wr(12'h000, 32'h0100_0100);
    chk("R10 pin active high", 32'(pin), 32'd1);
    sens[6] = 9'd100; sens[0] = 9'd99; wait_smp(6, 1);
    wr(12'h028, 32'h40); rd(12'h028, 32'h0, "R7 shut clear");
    chk("R10 pin idle low", 32'(pin), 32'd0);
    chk("R9 reset-unit idle", 32'(rstu), 32'd0);

    // R4 disabled scan
    wr(12'h000, 32'h0001_0000);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (stb) cnt++; end
    chk("R4 no strobes", 32'(cnt), 32'd0);
    sens[3] = 9'd300;
    wr(12'h000, 32'h0001_0001); wait_smp(3, 2);
    wr(12'h000, 32'h0001_0000); wr(12'h000, 32'h0001_0001);
    wait_smp(3, 2); rd(12'h024, 32'h0, "R4 counter cleared");
    wait_smp(3, 1); rd(12'h024, 32'h8, "R4 fresh run");

    // R11 hot period
    wr(12'h140, 32'd40); wr(12'h144, 32'd16);
    gap(3, g); gap(3, g); gap(3, g);
    chk("R11 hot gap", 32'(g), 32'd16);
    sens[3] = 9'd100;
    gap(3, g); gap(3, g); gap(3, g);
    chk("R11 normal gap", 32'(g), 32'd40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule